// File: doc/BRIEF.md
# Serial secure key protocol engine

This block is the device side of a three-wire security key. The host drives a transaction enable, a serial clock and a bidirectional data line. On chip the data line is split into an input, an output and an output enable. The engine holds three register arrays: a 64-bit identity word, a 64-bit match word and 128 bits of secure storage. All key-side inputs are synchronised to the system clock, and their edges are detected by oversampling, so the serial clock must be several times slower than `clk_i`.

A transaction starts when the enable rises. The engine shifts in a 24-bit command word on rising serial-clock edges and presents it on `cmd_word_o` to a separate decoder. One system cycle after the 24th bit, it samples the decoder's verdict (`cmd_ok_i`, `cmd_wr_i`, `cmd_prog_i`).

In normal mode the engine then performs four steps:
- It drives the identity word out on falling edges.
- It shifts in 64 compare bits.
- It checks the compare bits against the match word.
- It serves 128 secure-storage cycles in the direction of the command.

If the compare fails, those 128 cycles return pseudo-random bits for a read and discard the data for a write. In program mode, the 128 bits after the command load the identity word first and then the match word. Every word moves least-significant bit first.

Top module: `skey_engine`

## Requirements
- R1: While the synchronised enable is low, `dq_oe_o` is 0. A fall of the enable aborts any phase and returns the engine to idle, and it drops a partial compare.
- R2: The 24 command bits are captured on rising serial-clock edges, least-significant bit first, so that the first bit sent ends up in `cmd_word_o[0]`.
- R3: If `cmd_ok_i` is 0 at the verdict cycle, the engine ignores the rest of the transaction. It drives nothing and changes no stored word.
- R4: In normal mode the 64 identity bits are driven, bit 0 first, with `dq_oe_o`=1, one bit per falling edge after the command.
- R5: Each rising serial-clock edge clears `dq_oe_o`. After the 128-bit secure phase, further clocks do not drive the line.
- R6: If the 64 compare bits (bit 0 first) equal the match word and `cmd_wr_i`=0, the 128 secure bits are driven out, bit 0 first.
- R7: If the compare matches and `cmd_wr_i`=1, the 128 bits that follow are stored, bit 0 first.
- R8: On a compare mismatch in a read, the 128 cycles are driven with bits from a 16-bit LFSR that is never zero, and not with the stored data.
- R9: On a compare mismatch in a write, the 128 bits are dropped and the secure storage is unchanged.
- R10: With `cmd_prog_i`=1 and `cmd_wr_i`=1, the first 64 bits after the command replace the identity word and the next 64 replace the match word.
- R11: A program request with `cmd_wr_i`=0 is treated as invalid and ignored, as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_en_i | input | 1 | Transaction enable from host |
| key_clk_i | input | 1 | Serial clock from host |
| dq_i | input | 1 | Serial data from host |
| cmd_ok_i | input | 1 | Decoder verdict: command accepted |
| cmd_wr_i | input | 1 | Decoder verdict: write direction |
| cmd_prog_i | input | 1 | Decoder verdict: program mode |
| cmd_word_o | output | 24 | Captured command word |
| dq_o | output | 1 | Serial data to host |
| dq_oe_o | output | 1 | Drive enable for the data line |

## Verification
The bench programs an identity word and a match word. It then runs granted writes and reads over several storage patterns: alternating bits, walking nibbles and all ones. The read-back tells a bit-order fault apart from a storage fault.

A wrong match word is used for both a read and a write. The denied read must differ from the stored data and must toggle. The denied write must leave a later granted read unchanged, which separates gating of the compare from gating of the data.

Three further cases are exercised:
- A rejected command.
- A program request with the read direction.
- An abort in the middle of the identity phase.

Each is followed by a granted read, which shows that the key's words are untouched and that the engine has returned to idle.

// File: rtl/skey_pkg.sv
package skey_pkg;
  typedef enum logic [3:0] {
    PH_IDLE, PH_CMD, PH_EVAL, PH_ID, PH_CMP, PH_SEC,
    PH_PID, PH_PMATCH, PH_DONE, PH_DEAD
  } phase_e;
endpackage

// File: rtl/skey_sync.sv
module skey_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sclk_i,
  input  logic d_i,
  output logic en_o,
  output logic d_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] en_s, clk_s, d_s;
  logic clk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_s  <= '0;
      clk_s <= '1;
      d_s   <= '0;
      clk_d <= 1'b1;
    end else begin
      en_s  <= {en_s[STAGES-2:0], en_i};
      clk_s <= {clk_s[STAGES-2:0], sclk_i};
      d_s   <= {d_s[STAGES-2:0], d_i};
      clk_d <= clk_s[STAGES-1];
    end
  end

  assign en_o   = en_s[STAGES-1];
  assign d_o    = d_s[STAGES-1];
  assign rise_o = clk_s[STAGES-1] & ~clk_d;
  assign fall_o = ~clk_s[STAGES-1] & clk_d;
endmodule

// File: rtl/skey_lfsr.sv
module skey_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic fb;
  // taps 16,14,13,11: maximal length, never reaches zero from a nonzero seed
  assign fb = state_o[W-1] ^ state_o[W-3] ^ state_o[W-4] ^ state_o[W-6];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= SEED[W-1:0];
    else         state_o <= {state_o[W-2:0], fb};
  end
endmodule

// File: rtl/skey_engine.sv
module skey_engine
  import skey_pkg::*;
#(
  parameter int CMD_W  = 24,
  parameter int ID_W   = 64,
  parameter int SEC_W  = 128,
  parameter int LFSR_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_en_i,
  input  logic             key_clk_i,
  input  logic             dq_i,
  input  logic             cmd_ok_i,
  input  logic             cmd_wr_i,
  input  logic             cmd_prog_i,
  output logic [CMD_W-1:0] cmd_word_o,
  output logic             dq_o,
  output logic             dq_oe_o
);
  localparam int CNT_W = $clog2(SEC_W);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] ID_LAST  = CNT_W'(ID_W - 1);
  localparam logic [CNT_W-1:0] SEC_LAST = CNT_W'(SEC_W - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ID_W-1:0]   id_q, match_q, cmp_q, cmp_next;
  logic [SEC_W-1:0]  sec_q;
  logic              wr_q, grant_q;
  logic              en_s, d_s, rise, fall;
  logic [LFSR_W-1:0] lfsr;

  skey_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .en_i(key_en_i), .sclk_i(key_clk_i), .d_i(dq_i),
    .en_o(en_s), .d_o(d_s), .rise_o(rise), .fall_o(fall)
  );

  skey_lfsr #(.W(LFSR_W)) u_lfsr (.clk_i, .rst_ni, .state_o(lfsr));

  always_comb begin
    cmp_next        = cmp_q;
    cmp_next[cnt_q] = d_s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      cmd_word_o <= '0;
      id_q       <= '0;
      match_q    <= '0;
      cmp_q      <= '0;
      sec_q      <= '0;
      wr_q       <= 1'b0;
      grant_q    <= 1'b0;
      dq_o       <= 1'b0;
      dq_oe_o    <= 1'b0;
    end else if (!en_s) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cmp_q   <= '0;
      grant_q <= 1'b0;
      dq_oe_o <= 1'b0;
    end else begin
      if (rise) dq_oe_o <= 1'b0;
      unique case (phase_q)
        PH_IDLE: phase_q <= PH_CMD;
        PH_CMD: if (rise) begin
          cmd_word_o <= {d_s, cmd_word_o[CMD_W-1:1]};
          cnt_q      <= (cnt_q == CMD_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == CMD_LAST) phase_q <= PH_EVAL;
        end
        PH_EVAL: begin
          wr_q <= cmd_wr_i;
          if (!cmd_ok_i || (cmd_prog_i && !cmd_wr_i)) phase_q <= PH_DEAD;
          else if (cmd_prog_i)                       phase_q <= PH_PID;
          else                                       phase_q <= PH_ID;
        end
        PH_ID: begin
          if (fall) begin
            dq_o    <= id_q[cnt_q];
            dq_oe_o <= 1'b1;
          end
          if (rise) begin
            cnt_q <= (cnt_q == ID_LAST) ? '0 : cnt_q + 1'b1;
            if (cnt_q == ID_LAST) phase_q <= PH_CMP;
          end
        end
        PH_CMP: if (rise) begin
          cmp_q <= cmp_next;
          cnt_q <= (cnt_q == ID_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == ID_LAST) begin
            grant_q <= (cmp_next == match_q);
            phase_q <= PH_SEC;
          end
        end
        PH_SEC: begin
          if (fall && !wr_q) begin
            dq_o    <= grant_q ? sec_q[cnt_q] : lfsr[0];
            dq_oe_o <= 1'b1;
          end
          if (rise) begin
            if (wr_q && grant_q) sec_q[cnt_q] <= d_s;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == SEC_LAST) phase_q <= PH_DONE;
          end
        end
        PH_PID: if (rise) begin
          id_q[cnt_q] <= d_s;
          cnt_q <= (cnt_q == ID_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == ID_LAST) phase_q <= PH_PMATCH;
        end
        PH_PMATCH: if (rise) begin
          match_q[cnt_q] <= d_s;
          cnt_q <= (cnt_q == ID_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == ID_LAST) phase_q <= PH_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/skey_engine_chk.sv
module skey_engine_chk
  import skey_pkg::*;
#(
  parameter int CMD_W  = 24,
  parameter int SEC_W  = 128,
  parameter int LFSR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_s,
  input logic              d_s,
  input logic              rise,
  input phase_e            phase_q,
  input logic              grant_q,
  input logic              wr_q,
  input logic [SEC_W-1:0]  sec_q,
  input logic [LFSR_W-1:0] lfsr,
  input logic [CMD_W-1:0]  cmd_word_o,
  input logic              dq_oe_o
);
  p_idle_hiz_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> !dq_oe_o);
  p_cmd_lsb_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_s && rise && phase_q == PH_CMD) |=> cmd_word_o[CMD_W-1] == $past(d_s));
  p_dead_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_DEAD |-> !dq_oe_o);
  p_rise_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !dq_oe_o);
  p_done_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_DONE |-> !dq_oe_o);
  p_lfsr_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr != '0);
  p_denied_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SEC && wr_q && !grant_q) |=> $stable(sec_q));
endmodule

bind skey_engine skey_engine_chk #(.CMD_W(CMD_W), .SEC_W(SEC_W), .LFSR_W(LFSR_W)) u_chk (
  .clk_i, .rst_ni, .en_s, .d_s, .rise, .phase_q, .grant_q, .wr_q,
  .sec_q, .lfsr, .cmd_word_o, .dq_oe_o
);

// File: tb/tb_skey_engine.sv
module tb_skey_engine;
  localparam int H = 8;
  logic clk = 0, rst_ni = 0;
  logic key_en = 0, key_clk = 1, dq = 0;
  logic ok = 0, wr = 0, prog = 0;
  logic [23:0] cmd_word;
  logic dq_o, dq_oe;
  int tests = 0, fails = 0, hiz_err = 0;

  skey_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .key_en_i(key_en), .key_clk_i(key_clk),
    .dq_i(dq), .cmd_ok_i(ok), .cmd_wr_i(wr), .cmd_prog_i(prog),
    .cmd_word_o(cmd_word), .dq_o(dq_o), .dq_oe_o(dq_oe)
  );

  always #2 clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit1(input logic din, output logic dout, output logic doe);
    key_clk = 0;
    wt(H);
    dout = dq_o; doe = dq_oe;
    dq = din;
    key_clk = 1;
    wt(H);
    if (dq_oe !== 1'b0) hiz_err++;
  endtask

  task automatic start(input logic [23:0] w, input logic k, input logic d, input logic p);
    logic o, e;
    ok = k; wr = d; prog = p;
    key_en = 1; wt(H);
    for (int i = 0; i < 24; i++) bit1(w[i], o, e);
  endtask

  task automatic stop();
    key_en = 0; wt(H);
  endtask

  task automatic xfer64(input logic [63:0] v, output logic [63:0] r, output logic all_oe);
    logic o, e;
    all_oe = 1;
    for (int i = 0; i < 64; i++) begin bit1(v[i], o, e); r[i] = o; all_oe &= e; end
  endtask

  task automatic xfer128(input logic [127:0] v, output logic [127:0] r,
                         output logic all_oe, output logic any_oe);
    logic o, e;
    all_oe = 1; any_oe = 0;
    for (int i = 0; i < 128; i++) begin
      bit1(v[i], o, e); r[i] = o; all_oe &= e; any_oe |= e;
    end
  endtask

  localparam logic [23:0] CMDW = 24'hA1B29D;
  localparam logic [63:0] IDV  = 64'hA5C3_0F96_1234_8E71;
  localparam logic [63:0] MTV  = 64'h5EC0_DE11_F00D_2468;

  task automatic read_all(output logic [63:0] idr, output logic [127:0] sr,
                          output logic ida, output logic sa, input logic [63:0] m);
    logic [63:0] dum; logic dummy_oe, any; logic [127:0] sr2;
    start(CMDW, 1, 0, 0);
    xfer64('0, idr, ida);
    xfer64(m, dum, dummy_oe);
    xfer128('0, sr, sa, any);
    xfer128('0, sr2, dummy_oe, any);
    chk("R5 no drive after secure phase", any, 0);
    stop();
  endtask

  task automatic write_all(input logic [63:0] m, input logic [127:0] v, input logic k, input logic p);
    logic [63:0] dum; logic a, any; logic [127:0] r;
    start(CMDW, k, 1, p);
    xfer64('0, dum, a);
    if (!k) chk("R3 rejected command no drive", a, 0);
    xfer64(m, dum, a);
    xfer128(v, r, a, any);
    if (!k) chk("R3 rejected command no drive", any, 0);
    stop();
  endtask

  initial begin
    logic [63:0] idr, dum; logic [127:0] sr, pat, kept; logic ida, sa, a, any;
    wt(4);
    chk("R1 reset no drive", dq_oe, 0);
    rst_ni = 1; wt(4);
    chk("R1 idle no drive", dq_oe, 0);

    // R10 program
    start(CMDW, 1, 1, 1);
    chk("R2 command capture", cmd_word, CMDW);
    xfer64(IDV, dum, a);
    xfer64(MTV, dum, a);
    stop();

    // R6 R7 sweep of patterns
    for (int p = 0; p < 3; p++) begin
      pat = (p == 0) ? {32{4'hA}} : (p == 1) ? 128'h0123456789ABCDEF_FEDCBA9876543210 : '1;
      write_all(MTV, pat, 1, 0);
      read_all(idr, sr, ida, sa, MTV);
      chk("R4 identity read", idr, IDV);
      chk("R10 identity programmed", ida, 1);
      chk("R6 secure read back", sr, pat);
      chk("R6 secure read driven", sa, 1);
    end
    kept = '1;

    // R9 mismatch write dropped
    write_all(~MTV, 128'h1, 1, 0);
    read_all(idr, sr, ida, sa, MTV);
    chk("R9 denied write kept storage", sr, kept);

    // R8 mismatch read is random
    read_all(idr, sr, ida, sa, MTV ^ 64'h1);
    chk("R8 denied read driven", sa, 1);
    chk("R8 denied read differs", (sr != kept) && (sr != '0), 1);

    // R3 rejected command
    write_all(MTV, 128'h0, 0, 0);
    read_all(idr, sr, ida, sa, MTV);
    chk("R3 rejected write kept storage", sr, kept);

    // R11 program with read direction ignored
    start(CMDW, 1, 0, 1);
    xfer64(~IDV, dum, a);
    chk("R11 no drive", a, 0);
    xfer64(~MTV, dum, a);
    stop();
    read_all(idr, sr, ida, sa, MTV);
    chk("R11 identity unchanged", idr, IDV);
    chk("R11 match unchanged", sr, kept);

    // R1 abort mid identity phase
    start(CMDW, 1, 0, 0);
    for (int i = 0; i < 10; i++) begin logic o, e; bit1(0, o, e); end
    key_clk = 0; wt(H);
    chk("R1 driving before abort", dq_oe, 1);
    key_clk = 1; wt(2);
    key_en = 0; wt(H);
    chk("R1 abort no drive", dq_oe, 0);
    read_all(idr, sr, ida, sa, MTV);
    chk("R1 clean restart identity", idr, IDV);
    chk("R1 clean restart storage", sr, kept);

    chk("R5 released on every rising edge", hiz_err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule